// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Bank

This block is an 8-bit general-purpose I/O bank. Software reaches it through a small register bus with three registers. The direction register sets each pin to input or output. The output latch holds the data that output pins drive. The port register returns the sampled pin levels, and writing it loads the output latch. Each pad receives an output enable and an output data bit for a tri-state buffer. The pad inputs pass through a two-stage synchronizer before any read path sees them.

A slave-mode input hands the pads to an external parallel slave-port data path. In that mode, the slave read strobe enables every pad driver and the slave's outgoing byte drives the pads. The direction and latch registers are left untouched and take control again when slave mode is cleared.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-low reset, the direction register reads all ones, the output latch reads zero, and `pad_oe` is all zero when not in slave mode.
- R2: A write with `bus_addr` = 2 loads the direction register, and a read at address 2 returns it.
- R3: Outside slave mode, `pad_oe[i]` is 1 exactly when direction bit i is 0, and `pad_out` equals the output latch.
- R4: A write with `bus_addr` = 1 loads the output latch. A read at address 1 returns the latch contents, not the pin level.
- R5: A write with `bus_addr` = 0 loads the output latch, the same as address 1.
- R6: A read at address 0 returns `pad_in` as it was two clock edges earlier. `sp_din` carries the same synchronized value.
- R7: With `slave_mode` = 1, every bit of `pad_oe` equals `sp_rd` and `pad_out` equals `sp_dout`. Entering and leaving slave mode changes neither register.
- R8: A write with `bus_addr` = 3 changes no register, and a read at address 3 returns zero.
- R9: Register writes reach the pad outputs at the next clock edge, not in the same cycle. Pins whose direction bit is unchanged keep a stable `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output data |
| slave_mode | input | 1 | Hands the pads to the slave-port path when 1 |
| sp_rd | input | 1 | Slave-port read strobe, enables all pad drivers in slave mode |
| sp_dout | input | 8 | Slave-port data driven onto the pads |
| sp_din | output | 8 | Synchronized pad data offered to the slave port |

## Verification
The bench builds the block with its default parameters: WIDTH = 8 and SYNC_STAGES = 2. At this width all 256 values can be swept through the latch path, the direction-to-enable path and the synchronized read path, so every bit pattern is covered on each. The two-stage synchronizer keeps the read latency small enough to check the old and new values at each edge one by one.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank.
// Assumes a 2-bit register address. Address 3 is unmapped.
package gpio_bank_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PORT  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } gpio_sel_e;

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pad inputs.
// Assumes STAGES >= 2. Each bit is synchronized on its own, so the bits
// are not guaranteed to be coherent with each other.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain, clearing it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_regs.sv
// Direction and output-latch registers with the bus read multiplexer.
// Assumes a single-cycle write strobe. Port (0) and latch (1) writes both
// load the latch. Reads are combinational.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  port_val,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  dir_q
);

    gpio_sel_e sel;
    assign sel = gpio_sel_e'(addr);

    // Update the output latch on port or latch writes. Reset value is zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (wr && (sel == SEL_PORT || sel == SEL_LATCH))
            lat_q <= wdata;
    end

    // Update the direction register. Reset value makes every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '1;
        else if (wr && sel == SEL_DIR)
            dir_q <= wdata;
    end

    // Select the read source for the current address.
    always_comb begin
        unique case (sel)
            SEL_PORT:  rdata = port_val;
            SEL_LATCH: rdata = lat_q;
            SEL_DIR:   rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_padmux.sv
// Chooses the pad driver controls, either from the registers or from the
// slave-port path. Assumes a direction bit of 1 means input. Each pin has
// its own generated selection cell.
module gpio_padmux #(
    parameter int WIDTH = 8
) (
    input  logic             slave_mode,
    input  logic             sp_rd,
    input  logic [WIDTH-1:0] sp_dout,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Pick the enable and data for one pin from the active owner.
        always_comb begin
            if (slave_mode) begin
                pad_oe[i]  = sp_rd;
                pad_out[i] = sp_dout[i];
            end else begin
                pad_oe[i]  = ~dir_q[i];
                pad_out[i] = lat_q[i];
            end
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// Top level of the bidirectional GPIO bank. It ties together the input
// synchronizer, the register file and the pad output selection.
// Assumes the pad_in signals are asynchronous to clk.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    input  logic              slave_mode,
    input  logic              sp_rd,
    input  logic [WIDTH-1:0]  sp_dout,
    output logic [WIDTH-1:0]  sp_din
);

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .port_val (pin_sync),
        .rdata    (bus_rdata),
        .lat_q    (lat_q),
        .dir_q    (dir_q)
    );

    gpio_padmux #(.WIDTH(WIDTH)) u_padmux (
        .slave_mode (slave_mode),
        .sp_rd      (sp_rd),
        .sp_dout    (sp_dout),
        .lat_q      (lat_q),
        .dir_q      (dir_q),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out)
    );

    assign sp_din = pin_sync;

endmodule

// File: rtl/gpio_bank_chk.sv
// Assertion checker for gpio_bank, attached through bind.
// Assumes a two-stage synchronizer for the port read-latency property.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out,
    input logic              slave_mode,
    input logic              sp_rd,
    input logic [WIDTH-1:0]  sp_dout,
    input logic [WIDTH-1:0]  lat_q,
    input logic [WIDTH-1:0]  dir_q
);

    logic [1:0] since_rst;

    // Count the clock edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (lat_q == '0 && dir_q == '1));

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DIR) |=> dir_q == $past(bus_wdata));

    // R3
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DIR) |=> (slave_mode || pad_oe == ~$past(bus_wdata)));

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_LATCH) |=> (lat_q == $past(bus_wdata)
            && (slave_mode || pad_out == $past(bus_wdata))));

    // R5
    port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_PORT) |=> lat_q == $past(bus_wdata));

    // R6
    port_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bus_addr == SEL_PORT) |-> bus_rdata == $past(pad_in, 2));

    // R7
    slave_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (pad_oe == {WIDTH{sp_rd}} && pad_out == sp_dout));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_NONE) |=> ($stable(lat_q) && $stable(dir_q)));

    // R9
    oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !(bus_wr && bus_addr == SEL_DIR)) |=> (slave_mode || $stable(pad_oe)));

endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .slave_mode (slave_mode),
    .sp_rd      (sp_rd),
    .sp_dout    (sp_dout),
    .lat_q      (lat_q),
    .dir_q      (dir_q)
);

// File: tb/gpio_bank_test.sv
// Self-checking bench for gpio_bank: exhaustive 8-bit sweeps of each path.
module gpio_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic       slave_mode = 1'b0;
    logic       sp_rd = 1'b0;
    logic [7:0] sp_dout = 8'h00;
    logic [7:0] sp_din;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    gpio_bank uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .slave_mode (slave_mode),
        .sp_rd      (sp_rd),
        .sp_dout    (sp_dout),
        .sp_din     (sp_din)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one write at a negedge. It lands at the next posedge, and the
    // task returns at the following negedge.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd1, rd); check("R1 latch", rd, 8'h00);
        bus_read(2'd2, rd); check("R1 dir", rd, 8'hFF);
        check("R1 oe", pad_oe, 8'h00);

        // R4 and R3: sweep the latch with all pins outputs
        bus_write(2'd2, 8'h00);
        pad_in = 8'hA5;
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd1, 8'(v));
            bus_read(2'd1, rd);
            check("R4 latch readback", rd, 8'(v));
            check("R3 pad_out", pad_out, 8'(v));
        end
        // R4 latch read is not the pin level
        bus_write(2'd1, 8'h3C);
        bus_read(2'd1, rd); check("R4 latch not pin", rd, 8'h3C);

        // R2 and R3: sweep direction
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd2, 8'(v));
            bus_read(2'd2, rd);
            check("R2 dir readback", rd, 8'(v));
            check("R3 oe", pad_oe, ~8'(v));
        end

        // R5 port write loads the latch
        bus_write(2'd0, 8'h96);
        bus_read(2'd1, rd); check("R5 latch via port", rd, 8'h96);

        // R6 port read after two edges, for every input pattern
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); pad_in = 8'(v);
            @(negedge clk); @(negedge clk);
            bus_read(2'd0, rd);
            check("R6 port read", rd, 8'(v));
            check("R6 sp_din", sp_din, 8'(v));
        end
        // R6 latency: one edge shows old, two edges show new
        @(negedge clk); pad_in = 8'h0F;
        @(negedge clk); @(negedge clk);
        pad_in = 8'hF0;
        @(negedge clk);
        bus_read(2'd0, rd); check("R6 one edge old", rd, 8'h0F);
        @(negedge clk);
        bus_read(2'd0, rd); check("R6 two edges new", rd, 8'hF0);

        // R9 write reaches pads only at the next edge; unchanged bits stable
        bus_write(2'd2, 8'hCF);
        check("R9 oe after dir CF", pad_oe, 8'h30);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'hC3; bus_wr = 1'b1;
        #1;
        check("R9 oe before edge", pad_oe, 8'h30);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 oe after edge", pad_oe, 8'h3C);
        bus_write(2'd1, 8'h5A);
        check("R9 oe unchanged by latch write", pad_oe, 8'h3C);

        // R7 slave mode takes the pads
        slave_mode = 1'b1; sp_rd = 1'b0; sp_dout = 8'hE7;
        #1;
        check("R7 oe strobe low", pad_oe, 8'h00);
        check("R7 data", pad_out, 8'hE7);
        sp_rd = 1'b1;
        #1;
        check("R7 oe strobe high", pad_oe, 8'hFF);
        @(negedge clk); @(negedge clk);
        slave_mode = 1'b0; sp_rd = 1'b0;
        #1;
        check("R7 oe restored", pad_oe, 8'h3C);
        check("R7 data restored", pad_out, 8'h5A);
        bus_read(2'd2, rd); check("R7 dir kept", rd, 8'hC3);

        // R8 unmapped address
        bus_write(2'd3, 8'h11);
        bus_read(2'd1, rd); check("R8 latch kept", rd, 8'h5A);
        bus_read(2'd2, rd); check("R8 dir kept", rd, 8'hC3);
        bus_read(2'd3, rd); check("R8 read zero", rd, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule